// File: doc/BRIEF.md
# System Clock Source Switch Sequencer

This block controls which source drives the system clock while the chip runs. It handles seven choices: the primary oscillator with and without the PLL, the fast RC oscillator (undivided, with its postscaler, or feeding the PLL), the secondary oscillator and the low-power RC. Software places a 3-bit target code on `new_src` and pulses `sw_req`. This sets the switch-enable bit. The sequencer then waits until the target reports ready, and for a PLL target also until the lock input is high. Once both hold, it updates the reported current-source code and clears the enable bit.

The block does not model oscillators or PLLs. Each source appears only as a ready handshake, and the PLL appears as a lock input. The start-up source is a parameter, and any class of source may be chosen for it. The block rejects a request that would run the PLL from the fast RC when the postscaler output is below 4 MHz. While a switch is in progress, the block holds one further request and starts it when the current switch completes.

Top module: `clk_switch_seq`

## Requirements
- R1: After reset, `cur_src` equals the parameter `RESET_SRC`, `sw_en` is 0 and `lock_flag` is 0.
- R2: A legal request (`sw_req` high while `sw_en` is 0) makes `sw_en` read 1 after the next rising clock edge.
- R3: For a non-PLL target, `cur_src` takes the requested code and `sw_en` clears on the first rising edge at which the target's ready input is high. The ready inputs are: codes 0 and 7 use `frc_rdy`, code 2 uses `pri_rdy`, code 4 uses `sec_rdy`, code 5 uses `lprc_rdy`.
- R4: For a PLL target (code 1 is the fast RC with PLL, code 3 is the primary with PLL), completion also needs `pll_lock` high. While lock is low, `cur_src` holds and `sw_en` stays 1.
- R5: A request is ignored, leaving `sw_en` at 0 and `cur_src` unchanged, in two cases. The first is code 1 while `div_sel` is greater than 1 (the postscaler output is 8 MHz >> `div_sel`, so only 0 and 1 give at least 4 MHz). The second is the reserved code 6.
- R6: The block can switch between code 2 and code 3 in either direction at run time.
- R7: A legal request made while `sw_en` is 1 is held. At completion, `cur_src` takes the first target and `sw_en` stays 1. The held target then completes under R3 or R4.
- R8: `lock_flag` is 1 only when `pll_lock` is 1 and either `cur_src` is a PLL code or a pending switch targets one.
- R9: While `sw_en` is 1 and the target is not ready, `cur_src` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| new_src | input | 3 | Requested source code |
| sw_req | input | 1 | One-cycle pulse that sets the switch-enable bit |
| div_sel | input | 3 | Fast RC postscaler shift (output = 8 MHz >> div_sel) |
| pri_rdy | input | 1 | Primary oscillator ready |
| sec_rdy | input | 1 | Secondary oscillator ready |
| frc_rdy | input | 1 | Fast RC oscillator ready |
| lprc_rdy | input | 1 | Low-power RC ready |
| pll_lock | input | 1 | PLL output stable |
| cur_src | output | 3 | Current source code |
| sw_en | output | 1 | Switch-enable bit; reads 1 while a switch is pending |
| lock_flag | output | 1 | Lock status of the selected PLL |

## Verification
The hardest case to reach is a queued request. A second request must arrive while the first target is still not ready, and the first must then complete so that the queued one starts in the same cycle. The stimulus holds the primary ready input low so that the first switch stalls. It then issues the second request and raises the primary ready input. The scoreboard expects two `cur_src` updates on consecutive edges, with `sw_en` staying high in between. A similar stall on the lock input covers the PLL wait and the timing of `lock_flag`.

// File: rtl/clk_switch_seq.sv
module clk_switch_seq #(
  parameter int SRC_W     = 3,
  parameter int DIV_W     = 3,
  parameter int MAX_DIV   = 1,
  parameter logic [2:0] RESET_SRC = 3'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] new_src,
  input  logic             sw_req,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             pri_rdy,
  input  logic             sec_rdy,
  input  logic             frc_rdy,
  input  logic             lprc_rdy,
  input  logic             pll_lock,
  output logic [SRC_W-1:0] cur_src,
  output logic             sw_en,
  output logic             lock_flag
);
  localparam logic [SRC_W-1:0] FRC     = SRC_W'(0);
  localparam logic [SRC_W-1:0] FRC_PLL = SRC_W'(1);
  localparam logic [SRC_W-1:0] PRI     = SRC_W'(2);
  localparam logic [SRC_W-1:0] PRI_PLL = SRC_W'(3);
  localparam logic [SRC_W-1:0] SEC     = SRC_W'(4);
  localparam logic [SRC_W-1:0] LPRC    = SRC_W'(5);
  localparam logic [SRC_W-1:0] RSVD    = SRC_W'(6);
  localparam logic [SRC_W-1:0] FRC_DIV = SRC_W'(7);

  logic [SRC_W-1:0] tgt, pend_src;
  logic pend, req_ok, tgt_rdy, done;

  function automatic logic is_pll(input logic [SRC_W-1:0] c);
    return (c == FRC_PLL) || (c == PRI_PLL);
  endfunction

  assign req_ok = sw_req && (new_src != RSVD) &&
                  !((new_src == FRC_PLL) && (div_sel > DIV_W'(MAX_DIV)));

  always_comb begin
    case (tgt)
      FRC, FRC_DIV: tgt_rdy = frc_rdy;
      FRC_PLL:      tgt_rdy = frc_rdy && pll_lock;
      PRI:          tgt_rdy = pri_rdy;
      PRI_PLL:      tgt_rdy = pri_rdy && pll_lock;
      SEC:          tgt_rdy = sec_rdy;
      LPRC:         tgt_rdy = lprc_rdy;
      default:      tgt_rdy = 1'b0;
    endcase
  end

  assign done      = sw_en && tgt_rdy;
  assign lock_flag = pll_lock && (is_pll(cur_src) || (sw_en && is_pll(tgt)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_src  <= RESET_SRC;
      tgt      <= RESET_SRC;
      pend_src <= RESET_SRC;
      sw_en    <= 1'b0;
      pend     <= 1'b0;
    end else begin
      if (done) cur_src <= tgt;
      if (!sw_en) begin
        if (req_ok) begin
          sw_en <= 1'b1;
          tgt   <= new_src;
        end
      end else if (done) begin
        if (pend)        tgt <= pend_src;
        else if (req_ok) tgt <= new_src;
        else             sw_en <= 1'b0;
      end
      if (sw_en && req_ok && !(done && !pend)) begin
        pend     <= 1'b1;
        pend_src <= new_src;
      end else if (done) begin
        pend <= 1'b0;
      end
    end
  end

  a_r3_done_takes_target: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_en) |-> cur_src == $past(tgt));
  a_r4_pll_waits_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && is_pll(tgt) && !pll_lock) |=> $stable(cur_src));
  a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && !tgt_rdy) |=> $stable(cur_src));
  a_r5_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en |-> tgt != RSVD));
  a_r7_pend_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> sw_en);
  a_r2_change_only_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_src) |-> $past(sw_en));
endmodule

// File: tb/test_clk_switch_seq.sv
module test_clk_switch_seq;
  logic clk = 0, rst_n = 0;
  logic [2:0] new_src = 0, div_sel = 0;
  logic sw_req = 0, pri_rdy = 0, sec_rdy = 0, frc_rdy = 1, lprc_rdy = 1, pll_lock = 0;
  logic [2:0] cur_src;
  logic sw_en, lock_flag;
  int total = 0, bad = 0;
  logic [2:0] exp_q[$];
  logic [2:0] last_cur;
  bit ended = 0;

  always #2 clk = ~clk;

  clk_switch_seq i_clk_switch_seq (
    .clk(clk), .rst_n(rst_n), .new_src(new_src), .sw_req(sw_req), .div_sel(div_sel),
    .pri_rdy(pri_rdy), .sec_rdy(sec_rdy), .frc_rdy(frc_rdy), .lprc_rdy(lprc_rdy),
    .pll_lock(pll_lock), .cur_src(cur_src), .sw_en(sw_en), .lock_flag(lock_flag));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic request(input logic [2:0] code);
    @(negedge clk);
    new_src = code;
    sw_req  = 1;
    @(negedge clk);
    sw_req  = 0;
    #1;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (cur_src !== last_cur) begin
        if (exp_q.size() == 0) chk(0, "R3 unexpected cur_src change", cur_src, last_cur);
        else begin
          logic [2:0] e;
          e = exp_q.pop_front();
          chk(cur_src == e, "R3 scoreboard cur_src", cur_src, e);
        end
        last_cur = cur_src;
      end
    end else last_cur = cur_src;
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    chk(cur_src == 0, "R1 reset cur_src", cur_src, 0);
    chk(sw_en == 0, "R1 reset sw_en", sw_en, 0);
    chk(lock_flag == 0, "R1 reset lock_flag", lock_flag, 0);

    exp_q.push_back(3'd5);
    request(3'd5);
    chk(sw_en == 1, "R2 enable set", sw_en, 1);
    step(1);
    chk(cur_src == 5, "R3 to low-power RC", cur_src, 5);
    chk(sw_en == 0, "R3 enable cleared", sw_en, 0);

    exp_q.push_back(3'd2);
    request(3'd2);
    step(5);
    chk(cur_src == 5, "R9 hold while primary not ready", cur_src, 5);
    chk(sw_en == 1, "R9 enable held", sw_en, 1);
    pri_rdy = 1;
    step(1);
    chk(cur_src == 2, "R3 to primary", cur_src, 2);
    chk(sw_en == 0, "R3 enable cleared", sw_en, 0);

    exp_q.push_back(3'd3);
    request(3'd3);
    step(4);
    chk(cur_src == 2, "R4 waits for lock", cur_src, 2);
    chk(sw_en == 1, "R4 enable held", sw_en, 1);
    chk(lock_flag == 0, "R8 no lock yet", lock_flag, 0);
    @(negedge clk);
    pll_lock = 1;
    #1;
    chk(lock_flag == 1, "R8 lock flag with pending PLL", lock_flag, 1);
    step(1);
    chk(cur_src == 3, "R6 primary to primary PLL", cur_src, 3);
    chk(sw_en == 0, "R4 enable cleared", sw_en, 0);

    exp_q.push_back(3'd2);
    request(3'd2);
    step(1);
    chk(cur_src == 2, "R6 primary PLL back to primary", cur_src, 2);
    chk(lock_flag == 0, "R8 flag drops off PLL", lock_flag, 0);

    div_sel = 3'd2;
    request(3'd1);
    chk(sw_en == 0, "R5 slow postscaler PLL ignored", sw_en, 0);
    step(2);
    chk(cur_src == 2, "R5 cur unchanged", cur_src, 2);
    request(3'd6);
    chk(sw_en == 0, "R5 reserved ignored", sw_en, 0);
    step(1);
    chk(cur_src == 2, "R5 cur unchanged reserved", cur_src, 2);
    div_sel = 3'd1;
    exp_q.push_back(3'd1);
    request(3'd1);
    step(1);
    chk(cur_src == 1, "R5 4 MHz postscaler PLL accepted", cur_src, 1);

    pri_rdy = 0;
    sec_rdy = 1;
    exp_q.push_back(3'd2);
    exp_q.push_back(3'd4);
    request(3'd2);
    request(3'd4);
    chk(sw_en == 1, "R7 still busy", sw_en, 1);
    chk(cur_src == 1, "R7 first not done", cur_src, 1);
    @(negedge clk);
    pri_rdy = 1;
    step(1);
    chk(cur_src == 2, "R7 first target done", cur_src, 2);
    chk(sw_en == 1, "R7 held request running", sw_en, 1);
    step(1);
    chk(cur_src == 4, "R7 held target done", cur_src, 4);
    chk(sw_en == 0, "R7 enable cleared", sw_en, 0);

    step(2);
    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule